// File: doc/BRIEF.md
# Infrared Command Transmitter

This block sends one 8-bit command byte as a pulse-position-modulated infrared frame on an active-low output pin. A start strobe captures the byte, and the block then plays a frame of fixed-width mark bursts separated by spaces. The length of each space encodes one data bit. A long header burst opens the frame, the bits follow least significant first, and a short stop burst closes it. A one-cycle done pulse ends the frame, and busy stays high from the cycle after the start until that pulse.

Marks can be filled with a carrier near 38 kHz that is high for three quarters of its period. A parameter divides the system clock to make this carrier; with a 3 MHz clock the default divider of 79 gives about 38 kHz. A source-select input chooses what drives the pin. In hardware mode the frame engine drives it, and the carrier inside marks can be switched off. In manual mode a stop-output bit gates the carrier straight onto the pin, and the carrier is always on whatever the carrier-enable input says.

Top module: `ir_cmd_tx`

## Requirements
- R1: After reset, busy and done are 0 and ir_n is 1.
- R2: A start seen at a clock edge while idle is accepted: busy reads 1 in the following cycle and the carrier phase restarts at zero.
- R3: A frame has this order: a header mark of HDR_MARK_P carrier periods, a header space of HDR_SPACE_P periods, then DATA_W bits with bit 0 first, then a stop mark of UNIT_P periods. Each bit is a mark of UNIT_P periods followed by a space of UNIT_P periods for a 0 or 3*UNIT_P periods for a 1.
- R4: In hardware mode (hw_sel=1) with car_en=1, each carrier period inside a mark drives ir_n low for (3*CAR_DIV)/4 clock cycles and then high for the rest of the period.
- R5: In hardware mode with car_en=0, ir_n is held low through every mark.
- R6: In hardware mode, ir_n is 1 during spaces and while idle, whatever stop_bit says.
- R7: In manual mode (hw_sel=0), ir_n is low exactly during the carrier high phase when stop_bit=1, regardless of car_en, and stays 1 when stop_bit=0.
- R8: A start that arrives while busy is ignored: the frame in progress keeps its waveform and length.
- R9: After the last cycle of the stop mark, exactly one cycle follows with busy=1, done=1 and ir_n=1. Busy is 0 in the cycle after that. A frame lasts (total periods)*CAR_DIV+1 cycles.
- R10: The byte is captured at the accepting edge, and changes on data during a frame have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Transmit request strobe |
| data | input | DATA_W | Command byte to send |
| hw_sel | input | 1 | 1: frame engine drives pin; 0: stop bit drives pin |
| car_en | input | 1 | Carrier inside marks in hardware mode |
| stop_bit | input | 1 | Manual-mode gate for the carrier |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse at the end of a frame |
| ir_n | output | 1 | Infrared drive, active low |

## Verification
Busy and ir_n both come from registers through logic without further registers, so the first frame cycle can be seen right after the accepting edge. The bench drives inputs and samples outputs on falling edges. It records ir_n in every busy cycle, starting with the first one, and compares that record cycle by cycle with a waveform built from the segment rules. The recorded length must equal the periods times the divider plus one. The done pulse must fall in the last recorded cycle. Manual mode and idle checks count low cycles over a whole number of carrier periods, so the result does not depend on the carrier phase.

// File: rtl/ir_cmd_tx.sv
module ir_cmd_tx #(
  parameter int DATA_W     = 8,
  parameter int CAR_DIV    = 79,
  parameter int UNIT_P     = 21,
  parameter int HDR_MARK_P = 168,
  parameter int HDR_SPACE_P = 84
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] data,
  input  logic              hw_sel,
  input  logic              car_en,
  input  logic              stop_bit,
  output logic              busy,
  output logic              done,
  output logic              ir_n
);
  localparam int CAR_HIGH = (3 * CAR_DIV) / 4;
  localparam int CW = $clog2(CAR_DIV);
  localparam int M1 = (HDR_MARK_P > HDR_SPACE_P) ? HDR_MARK_P : HDR_SPACE_P;
  localparam int MAXP = (M1 > 3 * UNIT_P) ? M1 : 3 * UNIT_P;
  localparam int PW = $clog2(MAXP + 1);
  localparam int BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  typedef enum logic [2:0] {
    S_IDLE, S_HMARK, S_HSPACE, S_BMARK, S_BSPACE, S_SMARK, S_FIN
  } st_t;

  st_t              st;
  logic [CW-1:0]    car_cnt;
  logic [PW-1:0]    per_cnt;
  logic [PW-1:0]    seg_p;
  logic [BW-1:0]    bit_idx;
  logic [DATA_W-1:0] shreg;

  logic accept, car_wrap, car_hi, in_mark, hw_emit, man_emit;

  assign accept   = start && (st == S_IDLE);
  assign car_wrap = (car_cnt == CW'(CAR_DIV - 1));
  assign car_hi   = (car_cnt < CW'(CAR_HIGH));
  assign in_mark  = (st == S_HMARK) || (st == S_BMARK) || (st == S_SMARK);
  assign busy     = (st != S_IDLE);
  assign done     = (st == S_FIN);
  assign hw_emit  = in_mark && (!car_en || car_hi);
  assign man_emit = stop_bit && car_hi;
  assign ir_n     = ~(hw_sel ? hw_emit : man_emit);

  always_comb begin
    case (st)
      S_HMARK:  seg_p = PW'(HDR_MARK_P);
      S_HSPACE: seg_p = PW'(HDR_SPACE_P);
      S_BSPACE: seg_p = shreg[0] ? PW'(3 * UNIT_P) : PW'(UNIT_P);
      S_BMARK,
      S_SMARK:  seg_p = PW'(UNIT_P);
      default:  seg_p = PW'(1);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      car_cnt <= '0;
      per_cnt <= '0;
      bit_idx <= '0;
      shreg   <= '0;
    end else begin
      car_cnt <= (car_wrap || accept) ? '0 : car_cnt + CW'(1);
      case (st)
        S_IDLE: if (start) begin
          st      <= S_HMARK;
          shreg   <= data;
          per_cnt <= '0;
          bit_idx <= '0;
        end
        S_FIN: st <= S_IDLE;
        default: if (car_wrap) begin
          if (per_cnt == seg_p - PW'(1)) begin
            per_cnt <= '0;
            case (st)
              S_HMARK:  st <= S_HSPACE;
              S_HSPACE: st <= S_BMARK;
              S_BMARK:  st <= S_BSPACE;
              S_BSPACE: begin
                shreg <= shreg >> 1;
                if (bit_idx == BW'(DATA_W - 1)) st <= S_SMARK;
                else begin
                  bit_idx <= bit_idx + BW'(1);
                  st      <= S_BMARK;
                end
              end
              default:  st <= S_FIN;
            endcase
          end else begin
            per_cnt <= per_cnt + PW'(1);
          end
        end
      endcase
    end
  end

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && st == S_HMARK && car_cnt == '0));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!busy && !done));

  // R8
  retrigger_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && start) |=> busy);

  // R3
  period_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (per_cnt < seg_p));

  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_sel && !busy) |-> ir_n);

  // R7
  manual_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hw_sel && !stop_bit) |-> ir_n);
endmodule

// File: tb/ir_cmd_tx_tb_top.sv
`timescale 1ns/1ps
module ir_cmd_tx_tb_top;
  localparam int P  = 8;
  localparam int U  = 2;
  localparam int HM = 8;
  localparam int HS = 4;
  localparam int DW = 8;
  localparam int HI = (3 * P) / 4;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic hw_sel = 1'b1, car_en = 1'b0, stop_bit = 1'b0;
  logic [DW-1:0] data = '0;
  logic busy, done, ir_n;

  int checks = 0, errors = 0;
  logic exp_w [0:1023];
  logic got_w [0:1023];
  int exp_len, got_len, done_cnt, done_pos;

  always #2.5 clk = ~clk;

  ir_cmd_tx #(.DATA_W(DW), .CAR_DIV(P), .UNIT_P(U), .HDR_MARK_P(HM), .HDR_SPACE_P(HS)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .data(data), .hw_sel(hw_sel),
    .car_en(car_en), .stop_bit(stop_bit), .busy(busy), .done(done), .ir_n(ir_n));

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic push(input logic v);
    exp_w[exp_len] = v;
    exp_len++;
  endtask

  task automatic seg(input int n, input bit mark, input bit car);
    for (int p = 0; p < n; p++)
      for (int j = 0; j < P; j++)
        push(mark ? ((!car || j < HI) ? 1'b0 : 1'b1) : 1'b1);
  endtask

  task automatic build(input logic [DW-1:0] d, input bit car);
    exp_len = 0;
    seg(HM, 1'b1, car);
    seg(HS, 1'b0, car);
    for (int b = 0; b < DW; b++) begin
      seg(U, 1'b1, car);
      seg(d[b] ? 3 * U : U, 1'b0, car);
    end
    seg(U, 1'b1, car);
    push(1'b1);
  endtask

  task automatic send(input logic [DW-1:0] d, input int rt_at, input logic [DW-1:0] d2);
    @(negedge clk);
    start = 1'b1;
    data  = d;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2", "busy after accept", int'(busy), 1);
    got_len = 0; done_cnt = 0; done_pos = -1;
    while (busy && got_len < 1024) begin
      got_w[got_len] = ir_n;
      if (done) begin
        done_cnt++;
        done_pos = got_len;
      end
      got_len++;
      if (got_len == rt_at) begin
        start = 1'b1;
        data  = d2;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  task automatic compare(input string req);
    int mism, first;
    mism = 0; first = -1;
    for (int i = 0; i < exp_len && i < got_len; i++)
      if (got_w[i] !== exp_w[i]) begin
        mism++;
        if (first < 0) first = i;
      end
    chk(got_len == exp_len, "R9", "frame length", got_len, exp_len);
    chk(mism == 0, req, "waveform mismatches (first at cycle shown as actual)", first, -1);
    chk(done_cnt == 1 && done_pos == exp_len - 1, "R9", "done position", done_pos, exp_len - 1);
    chk(busy == 1'b0, "R9", "busy after frame", int'(busy), 0);
  endtask

  task automatic t_reset();
    chk(busy == 1'b0, "R1", "busy at reset", int'(busy), 0);
    chk(done == 1'b0, "R1", "done at reset", int'(done), 0);
    chk(ir_n == 1'b1, "R1", "ir_n at reset", int'(ir_n), 1);
  endtask

  task automatic t_plain(input logic [DW-1:0] d);
    hw_sel = 1'b1; car_en = 1'b0;
    build(d, 1'b0);
    send(d, -1, '0);
    compare("R3 R5");
  endtask

  task automatic t_carrier(input logic [DW-1:0] d);
    hw_sel = 1'b1; car_en = 1'b1; stop_bit = 1'b1;
    build(d, 1'b1);
    send(d, -1, '0);
    compare("R4 R6");
    stop_bit = 1'b0;
  endtask

  task automatic t_retrigger();
    hw_sel = 1'b1; car_en = 1'b0;
    build(8'h96, 1'b0);
    send(8'h96, 150, 8'h0F);
    compare("R8 R10");
  endtask

  task automatic t_idle_hw();
    int lows;
    hw_sel = 1'b1; stop_bit = 1'b1; car_en = 1'b1; lows = 0;
    for (int i = 0; i < 10 * P; i++) begin
      @(negedge clk);
      if (!ir_n) lows++;
    end
    chk(lows == 0, "R6", "idle lows with stop_bit=1", lows, 0);
    stop_bit = 1'b0;
  endtask

  task automatic t_manual(input bit sb, input bit ce);
    int lows;
    hw_sel = 1'b0; stop_bit = sb; car_en = ce; lows = 0;
    @(negedge clk);
    for (int i = 0; i < 10 * P; i++) begin
      @(negedge clk);
      if (!ir_n) lows++;
    end
    chk(lows == (sb ? 10 * HI : 0), "R7", "manual lows", lows, sb ? 10 * HI : 0);
    hw_sel = 1'b1; stop_bit = 1'b0;
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_plain(8'hA5);
    t_plain(8'h00);
    t_plain(8'hFF);
    t_carrier(8'h3C);
    t_retrigger();
    t_idle_hw();
    t_manual(1'b1, 1'b0);
    t_manual(1'b1, 1'b1);
    t_manual(1'b0, 1'b1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule